// File: doc/BRIEF.md
# Hot-Swap Bus Connection Controller

This controller decides when a card's two-wire bus segment may be joined to a backplane segment that is already carrying traffic. It watches two supply-good indications, one for each side. Each indication comes as a pair of flags: a qualify flag for the upper threshold and a hold flag for the lower threshold. The controller also samples the data and clock levels on both segments. From these it sequences through four states: lockout, initialization, idle watch and linked.

While the card powers up, the controller asks for line precharge and holds the switch open. It then waits for the backplane to go quiet before it closes the switch. Quiet means either that all four lines have stayed high for an idle window, or that a stop condition has been seen on the backplane pair. Once the switch closes, precharge turns off and an external pin takes over the enable for the rise-time boost circuits. Analog thresholds and current sources are outside the block and appear only as flags and enables.

All asynchronous inputs pass through a parameterised synchronizer before the state machine uses them. Timer lengths are parameters given in clock cycles.

Top module: `hsw_link_ctrl`

## Requirements
- R1: While reset is asserted, link_on, prechg_en and accel_en are all 0.
- R2: The block leaves lockout only once both main_qual and card_qual are 1 (and both hold flags are 1). The two supplies may qualify in either order. A hold flag of 1 without its qualify flag keeps the block in lockout.
- R3: A 0 on main_hold or card_hold returns the block to lockout from any state within three clock cycles of the input change.
- R4: After lockout has been left, a 0 on a qualify flag while both hold flags stay 1 has no effect (hysteresis).
- R5: In lockout, link_on, prechg_en and accel_en are all 0.
- R6: prechg_en is 1 in initialization and in idle watch, and 0 once linked.
- R7: Initialization lasts ENABLE_CYC cycles. No connection is made during it, even when all lines are high or a backplane stop is seen.
- R8: In idle watch, the block connects after IDLE_CYC consecutive synchronized samples in which all four lines are high.
- R9: A low sample on any of the four lines restarts the idle count from zero.
- R10: In idle watch, a backplane stop connects the block within three cycles, without waiting for the idle window. A stop is the data line rising while the clock line is high both before and after the rise, with all four lines high.
- R11: A data rise that coincides with the clock rising is not a stop.
- R12: accel_en equals the synchronized accel_pin while linked, and is 0 in every other state.
- R13: Once linked, the block stays linked, whatever the lines do, until a hold flag drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_qual | input | 1 | Backplane supply above its upper threshold |
| main_hold | input | 1 | Backplane supply above its lower threshold |
| card_qual | input | 1 | Card supply above its upper threshold |
| card_hold | input | 1 | Card supply above its lower threshold |
| bp_sda | input | 1 | Sampled backplane data line level |
| bp_scl | input | 1 | Sampled backplane clock line level |
| cd_sda | input | 1 | Sampled card data line level |
| cd_scl | input | 1 | Sampled card clock line level |
| accel_pin | input | 1 | Rise-boost enable request, 1 = allow boost |
| link_on | output | 1 | Close the switch between the segments |
| prechg_en | output | 1 | Enable precharge on all four lines |
| accel_en | output | 1 | Enable rise-time boost on all four lines |

## Verification
The bench targets four kinds of fault.

- Off-by-one timers: a design that miscounts the initialization or idle window would connect one cycle early or late, and the per-cycle reference comparison catches it at the transition edge.
- Idle restart: clock glitches on the card side shorter than the idle window expose a design that pauses the idle count instead of restarting it, because such a design would connect while traffic continues.
- Stop recognition: stops are issued both during initialization and in idle watch, and data and clock are raised together. A design that accepts stops too early, or accepts a simultaneous rise as a stop, would link too soon.
- Hysteresis: dropping the qualify flags while linked shows whether a design wrongly uses the upper threshold to fall back to lockout.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

   typedef enum logic [1:0] {
      ST_LOCK  = 2'd0,
      ST_INIT  = 2'd1,
      ST_WATCH = 2'd2,
      ST_LINK  = 2'd3
   } link_state_t;

   // bit positions inside the synchronized input vector
   localparam int IDX_MAIN_QUAL = 0;
   localparam int IDX_MAIN_HOLD = 1;
   localparam int IDX_CARD_QUAL = 2;
   localparam int IDX_CARD_HOLD = 3;
   localparam int IDX_CD_SCL    = 4;
   localparam int IDX_CD_SDA    = 5;
   localparam int IDX_BP_SCL    = 6;
   localparam int IDX_BP_SDA    = 7;
   localparam int IDX_ACCEL     = 8;
   localparam int IN_W          = 9;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("hsw_sync: W must be at least 1");
      end
      if (STAGES < 2) begin : g_bad_st
         $error("hsw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= '0;
               else        pipe[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[g] <= '0;
               else        pipe[g] <= pipe[g-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/hsw_span_cnt.sv
module hsw_span_cnt #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic hit
);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("hsw_span_cnt: LIMIT must be at least 2");
      end
   endgenerate

   localparam int CW = $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   assign hit = step && !clr && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (step && !hit)   cnt <= cnt + 1'b1;
   end

   // R9: a clear always brings the count back to zero on the next cycle
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   // R8: the count never passes the last position of the window
   a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

endmodule

// File: rtl/hsw_stop_seen.sv
module hsw_stop_seen (
   input  logic clk,
   input  logic rst_n,
   input  logic sda,
   input  logic scl,
   output logic stop
);

   logic sda_d, scl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_d <= 1'b1;
         scl_d <= 1'b0;
      end else begin
         sda_d <= sda;
         scl_d <= scl;
      end
   end

   // data rise with clock high on both sides of the rise (R10, R11)
   assign stop = !sda_d && sda && scl_d && scl;

   // R11: a rise of clock together with data never counts as a stop
   a_r11_no_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_d && scl) |-> !stop);

endmodule

// File: rtl/hsw_link_ctrl.sv
module hsw_link_ctrl
   import hsw_pkg::*;
#(
   parameter int ENABLE_CYC  = 18000,
   parameter int IDLE_CYC    = 14000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_qual,
   input  logic main_hold,
   input  logic card_qual,
   input  logic card_hold,
   input  logic bp_sda,
   input  logic bp_scl,
   input  logic cd_sda,
   input  logic cd_scl,
   input  logic accel_pin,
   output logic link_on,
   output logic prechg_en,
   output logic accel_en
);

   generate
      if (ENABLE_CYC < 2 || IDLE_CYC < 2) begin : g_bad_tmr
         $error("hsw_link_ctrl: timer lengths must be at least 2");
      end
   endgenerate

   logic [IN_W-1:0] raw, syn;

   always_comb begin
      raw                = '0;
      raw[IDX_MAIN_QUAL] = main_qual;
      raw[IDX_MAIN_HOLD] = main_hold;
      raw[IDX_CARD_QUAL] = card_qual;
      raw[IDX_CARD_HOLD] = card_hold;
      raw[IDX_CD_SCL]    = cd_scl;
      raw[IDX_CD_SDA]    = cd_sda;
      raw[IDX_BP_SCL]    = bp_scl;
      raw[IDX_BP_SDA]    = bp_sda;
      raw[IDX_ACCEL]     = accel_pin;
   end

   hsw_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   logic bp_stop;

   hsw_stop_seen u_stop (
      .clk   (clk),
      .rst_n (rst_n),
      .sda   (syn[IDX_BP_SDA]),
      .scl   (syn[IDX_BP_SCL]),
      .stop  (bp_stop)
   );

   link_state_t state, state_nx;

   logic all_hi, supply_up, supply_drop;
   assign all_hi      = syn[IDX_CD_SCL] && syn[IDX_CD_SDA] &&
                        syn[IDX_BP_SCL] && syn[IDX_BP_SDA];
   assign supply_up   = syn[IDX_MAIN_QUAL] && syn[IDX_CARD_QUAL];
   assign supply_drop = !(syn[IDX_MAIN_HOLD] && syn[IDX_CARD_HOLD]);

   logic en_done, idle_done;

   hsw_span_cnt #(.LIMIT(ENABLE_CYC)) u_en_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state != ST_INIT),
      .step  (state == ST_INIT),
      .hit   (en_done)
   );

   hsw_span_cnt #(.LIMIT(IDLE_CYC)) u_idle_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   ((state != ST_WATCH) || !all_hi),
      .step  ((state == ST_WATCH) && all_hi),
      .hit   (idle_done)
   );

   always_comb begin
      state_nx = state;
      if (supply_drop) begin
         state_nx = ST_LOCK;
      end else begin
         unique case (state)
            ST_LOCK:  if (supply_up) state_nx = ST_INIT;
            ST_INIT:  if (en_done)   state_nx = ST_WATCH;
            ST_WATCH: if (idle_done || (bp_stop && all_hi)) state_nx = ST_LINK;
            ST_LINK:  state_nx = ST_LINK;
            default:  state_nx = ST_LOCK;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_LOCK;
      else        state <= state_nx;
   end

   assign link_on   = (state == ST_LINK);
   assign prechg_en = (state == ST_INIT) || (state == ST_WATCH);
   assign accel_en  = (state == ST_LINK) && syn[IDX_ACCEL];

   // R3: a dropped hold flag forces lockout on the next cycle
   a_r3_dropout: assert property (@(posedge clk) disable iff (!rst_n)
      supply_drop |=> (state == ST_LOCK));

   // R2: lockout is kept until both supplies qualify
   a_r2_need_both: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOCK && !supply_up) |=> (state == ST_LOCK));

   // R13: the link holds until a supply dropout
   a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LINK && !supply_drop) |=> link_on);

   // R7: initialization never jumps straight to linked
   a_r7_no_early: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_INIT) |=> !link_on);

   // R10: a qualified backplane stop in idle watch closes the switch
   a_r10_stop_links: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WATCH && !supply_drop && bp_stop && all_hi) |=> link_on);

   // R12: boost only ever runs on a joined bus
   a_r12_accel_linked: assert property (@(posedge clk) disable iff (!rst_n)
      accel_en |-> link_on);

   // R6: precharge and the link are never on together
   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      link_on |-> !prechg_en);

endmodule

// File: tb/hsw_link_ctrl_test.sv
module hsw_link_ctrl_test;

   localparam int CLK_PER = 10;
   localparam int EN      = 20;
   localparam int IDLE    = 12;
   localparam int WDOG    = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   // {accel, bp_sda, bp_scl, cd_sda, cd_scl, card_hold, card_qual, main_hold, main_qual}
   logic [8:0] vin = '0;
   logic link_on, prechg_en, accel_en;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   hsw_link_ctrl #(.ENABLE_CYC(EN), .IDLE_CYC(IDLE), .SYNC_STAGES(2)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .main_qual (vin[0]),
      .main_hold (vin[1]),
      .card_qual (vin[2]),
      .card_hold (vin[3]),
      .bp_sda    (vin[7]),
      .bp_scl    (vin[6]),
      .cd_sda    (vin[5]),
      .cd_scl    (vin[4]),
      .accel_pin (vin[8]),
      .link_on   (link_on),
      .prechg_en (prechg_en),
      .accel_en  (accel_en)
   );

   // behavioural reference: 0 lockout, 1 init, 2 watch, 3 linked
   int m_st = 0, m_en = 0, m_idle = 0;
   logic [8:0] h1 = '0, h2 = '0;
   bit prev_sda = 1'b1, prev_scl = 1'b0;
   bit e_link = 0, e_pre = 0, e_acc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_en = 0; m_idle = 0;
         h1 = '0; h2 = '0; prev_sda = 1'b1; prev_scl = 1'b0;
      end else begin
         bit hi, stp;
         hi  = h2[7] && h2[6] && h2[5] && h2[4];
         stp = !prev_sda && h2[7] && prev_scl && h2[6];
         if (!(h2[1] && h2[3])) begin
            m_st = 0; m_en = 0; m_idle = 0;
         end else if (m_st == 0) begin
            if (h2[0] && h2[2]) begin m_st = 1; m_en = 0; end
         end else if (m_st == 1) begin
            m_en++;
            if (m_en == EN) begin m_st = 2; m_idle = 0; end
         end else if (m_st == 2) begin
            if (hi) begin
               m_idle++;
               if (m_idle == IDLE || stp) m_st = 3;
            end else begin
               m_idle = 0;
            end
         end
         prev_sda = h2[7];
         prev_scl = h2[6];
         h2 = h1;
         h1 = vin;
      end
      e_link = (m_st == 3);
      e_pre  = (m_st == 1) || (m_st == 2);
      e_acc  = (m_st == 3) && h2[8];
   end

   task automatic check(input string tag, input logic got, input logic exp, input string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (!done) begin
         string tag;
         case (m_st)
            0: tag = "R5";
            1: tag = "R7";
            2: tag = "R8";
            default: tag = "R13";
         endcase
         check(tag, link_on,   e_link, "model link_on");
         check(tag, prechg_en, e_pre,  "model prechg_en");
         check("R12", accel_en, e_acc, "model accel_en");
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drop_and_restore();
      vin[1] = 1'b0; vin[0] = 1'b0; vin[3] = 1'b0; vin[2] = 1'b0;
      step(4);
      check("R3", link_on, 1'b0, "link after dropout");
      check("R5", prechg_en, 1'b0, "precharge in lockout");
      vin[3:0] = 4'b1111;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WDOG && !done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      step(3);
      check("R1", link_on, 1'b0, "link in reset");
      check("R1", prechg_en, 1'b0, "precharge in reset");
      check("R1", accel_en, 1'b0, "accel in reset");
      rst_n = 1'b1;

      // R2: only the backplane supply is up, lines high
      vin[8:4] = 5'b11111;
      vin[1:0] = 2'b11;
      step(10);
      check("R2", prechg_en, 1'b0, "one supply only");
      vin[3:2] = 2'b11;
      step(5);
      check("R6", prechg_en, 1'b1, "precharge in init");
      step(10);
      check("R7", link_on, 1'b0, "link during init");
      step(EN + IDLE);
      check("R8", link_on, 1'b1, "idle connect");
      check("R6", prechg_en, 1'b0, "precharge after link");
      check("R12", accel_en, 1'b1, "accel follows pin high");

      // R12: pin low while linked
      vin[8] = 1'b0;
      step(4);
      check("R12", accel_en, 1'b0, "accel follows pin low");
      vin[8] = 1'b1;
      step(4);
      check("R12", accel_en, 1'b1, "accel back on");

      // R4 and R13: qualify flags drop, holds stay, lines toggle
      vin[0] = 1'b0; vin[2] = 1'b0;
      step(10);
      check("R4", link_on, 1'b1, "link kept through qualify drop");
      vin[5] = 1'b0;
      step(5);
      check("R13", link_on, 1'b1, "link kept with low line");
      vin[5] = 1'b1;

      // R3 then R2 hysteresis in lockout: holds up, qualifies down
      vin[3] = 1'b0;
      step(4);
      check("R3", link_on, 1'b0, "card hold drop");
      check("R5", accel_en, 1'b0, "accel in lockout");
      vin[3] = 1'b1;
      step(8);
      check("R2", prechg_en, 1'b0, "holds without qualify");
      vin[2] = 1'b1;
      step(5);
      check("R2", prechg_en, 1'b0, "card qualifies first");
      vin[0] = 1'b1;
      step(EN + 5);
      check("R6", prechg_en, 1'b1, "in idle watch");

      // R9: short card clock pulses restart the idle window
      for (int i = 0; i < 6; i++) begin
         vin[4] = 1'b0;
         step(1);
         vin[4] = 1'b1;
         step(IDLE - 4);
         check("R9", link_on, 1'b0, "idle restarted by low");
      end
      step(IDLE + 5);
      check("R8", link_on, 1'b1, "idle connect after glitches");

      // R7: stop during init is ignored; R10: stop in watch connects
      vin[7] = 1'b0;
      drop_and_restore();
      step(8);
      vin[7] = 1'b1;
      step(4);
      check("R7", link_on, 1'b0, "stop during init");
      vin[7] = 1'b0;
      step(EN + 5);
      check("R10", link_on, 1'b0, "watch with data low");
      check("R10", prechg_en, 1'b1, "still precharging");
      vin[7] = 1'b1;
      step(4);
      check("R10", link_on, 1'b1, "stop connects");

      // R11: data and clock rise together
      vin[7] = 1'b0; vin[6] = 1'b0;
      drop_and_restore();
      step(EN + 8);
      vin[7] = 1'b1; vin[6] = 1'b1;
      step(4);
      check("R11", link_on, 1'b0, "joint rise is no stop");
      step(IDLE + 2);
      check("R8", link_on, 1'b1, "idle connect after joint rise");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule